// File: doc/BRIEF.md
# Protection Register Bank with Indirect Test Access

This block holds the 32-bit configuration and status registers of a core memory-protection unit. The registers fall into two mirrored groups, one serving data accesses and one serving instruction fetches. Each group has a control word, two logged-fault registers, sixteen descriptor address and sixteen descriptor attribute words, a test command word and a pair of test data words. The instruction group sits 0x1000 above the data group. A simple word-wide register bus reads and writes them. Bus responses, read data and the error flag appear one cycle after the request.

A separate fault-logger input is the only path that updates the fault status and fault address words. The bus can read them but cannot change them.

Writing a nonzero command to the data-side test command word starts an indirect access to level-1 SRAM. The block scatters command fields into an SRAM byte address, ORs in the fixed SRAM base, and moves 64 bits between the two test data words and the SRAM in two 32-bit beats, lower word first. Commands it cannot serve are refused with an error and make no SRAM access.

Top module: `prot_regbank`

## Requirements
- R1: Only full-word accesses (`bus_full`=1) are served. A narrower access gets `bus_err`=1 and read data 0, and a write changes nothing. This holds even at a valid offset, so the size check comes before the offset check.
- R2: An access to an offset with no register (any offset with bits 1:0 nonzero, page 0 word index 4 and up, descriptor index 16 and up, test command page index 1 and up, test data page index 2 and up, pages 5 to 15) gets `bus_err`=1 and read data 0.
- R3: After reset the SRAM base word (offset 0x000) reads 0xFF800000, both control words (0x004, 0x1004) read 0x00000001, and every other register reads 0.
- R4: Control words, descriptor address words (0x100+4i), descriptor attribute words (0x200+4i) and test data words (0x400, 0x404) of both groups can be written and read back. Each read returns its value in the cycle after the request.
- R5: Writes to the SRAM base word, the instruction-group filler word at 0x1000, and both groups' fault status (0x008) and fault address (0x00C) words are dropped without error. These words stay readable.
- R6: A `flt_valid` pulse loads `flt_status` and `flt_addr` into the fault words of the group chosen by `flt_inst` (0 = data group, 1 = instruction group).
- R7: The SRAM byte address of a test transfer is formed from the test command word and ORed with the base 0xFF800000:
  - address bit 11 takes command bit 26 (way);
  - address bit 21 takes command bit 24 (data/instruction memory);
  - address bit 15 takes command bit 23 (bank);
  - address bits 13:12 take command bits 17:16 (subbank);
  - address bits 14 and 10:3 take the same command bits.
- R8: A legal command with bit 1 set (write direction) puts test data word 0 on address A and then word 1 on A+4, one beat per cycle. `busy` is high for exactly 2 cycles.
- R9: A legal command with bit 1 clear (read direction) reads A and then A+4 over two beats and loads the words into test data words 0 and 1. `busy` is high for exactly 3 cycles.
- R10: A nonzero data-side command is refused if bit 2 (data-array select) is clear or if any bit of 0xFA7CB801 is set. Any nonzero instruction-side command (0x1300) is also refused. A refused command raises `bus_err` for one cycle and makes no SRAM access.
- R11: While `busy` is high, bus writes are ignored with no error. A zero test command starts no transfer and raises no error.
- R12: The data-side test command word reads back the last value written to it, whether or not the command was refused. The instruction-side test command word always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_full | input | 1 | 1 = full 32-bit access |
| bus_addr | input | 13 | Byte offset within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after request |
| bus_err | output | 1 | Access error, one cycle after request |
| busy | output | 1 | Test transfer in progress |
| flt_valid | input | 1 | Fault logger update strobe |
| flt_inst | input | 1 | Fault group: 0 data, 1 instruction |
| flt_status | input | 32 | Fault status value to log |
| flt_addr | input | 32 | Faulting address to log |
| sram_en | output | 1 | SRAM beat enable |
| sram_we | output | 1 | SRAM beat is a write |
| sram_addr | output | 32 | SRAM byte address of the beat |
| sram_wdata | output | 32 | SRAM write word |
| sram_rdata | input | 32 | SRAM read word, one cycle after a read beat |

## Verification
The assertions assume the SRAM returns read data exactly one cycle after a read beat. They also assume the fault logger is the only agent allowed to change the fault words, and that its strobe is low through reset. The stimulus keeps to these assumptions with a bench SRAM that has a one-cycle read latency, and by driving `flt_valid` only from the fault-logging task. The one deliberate bus write during a transfer is the single case where the bench breaks the rule that the master waits for `busy` to fall.

// File: rtl/prot_regbank_pkg.sv
// Shared constants, kinds and command helpers for the protection register bank.
// Assumes byte offsets of 13 bits, with bit 12 selecting the instruction group.
package prot_regbank_pkg;

    localparam int BUS_AW = 13;
    localparam int WORD_W = 32;

    // Page numbers in offset bits 11:8; the neighbouring decoder relies on them.
    localparam logic [3:0] PG_MISC  = 4'd0;
    localparam logic [3:0] PG_DADDR = 4'd1;
    localparam logic [3:0] PG_DATTR = 4'd2;
    localparam logic [3:0] PG_TCMD  = 4'd3;
    localparam logic [3:0] PG_TDATA = 4'd4;

    localparam logic [WORD_W-1:0] UNDEF_MASK   = 32'hFA7C_B801;
    localparam logic [WORD_W-1:0] INPLACE_MASK = 32'h0000_47F8;
    localparam int CMD_ARRAY_BIT = 2;
    localparam int CMD_WRITE_BIT = 1;

    typedef enum logic [3:0] {
        K_NONE, K_BASE, K_FILL, K_CTRL, K_FSTAT, K_FADDR,
        K_DADDR, K_DATTR, K_TCMD, K_TDATA
    } reg_kind_e;

    typedef enum logic [1:0] {
        XS_IDLE, XS_BEAT0, XS_BEAT1, XS_TAIL
    } xfer_state_e;

    // Scatter command fields into an SRAM byte address and OR in the base.
    function automatic logic [WORD_W-1:0] form_line_addr(
        input logic [WORD_W-1:0] cmd, input logic [WORD_W-1:0] base);
        logic [WORD_W-1:0] scat;
        scat         = '0;
        scat[11]     = cmd[26];
        scat[21]     = cmd[24];
        scat[15]     = cmd[23];
        scat[13:12]  = cmd[17:16];
        return base | scat | (cmd & INPLACE_MASK);
    endfunction

    // A command is servable when it selects the data array and no undefined bit.
    function automatic logic cmd_legal(input logic [WORD_W-1:0] cmd);
        return cmd[CMD_ARRAY_BIT] && ((cmd & UNDEF_MASK) == '0);
    endfunction

endpackage

// File: rtl/pr_addr_decode.sv
// Decodes a bus byte offset into register kind, group and word index.
// Assumes the caller rejects anything reported with hit low.
module pr_addr_decode
    import prot_regbank_pkg::*;
#(
    parameter int NDESC = 16,
    localparam int IW = (NDESC > 1) ? $clog2(NDESC) : 1
) (
    input  logic [BUS_AW-1:0] addr,
    output logic              hit,
    output logic              side,
    output reg_kind_e         kind,
    output logic [IW-1:0]     dsc_idx,
    output logic              word_sel
);
    localparam logic [6:0] NDESC_L = 7'(NDESC);

    logic [5:0] widx;

    // Pick the register kind from page and word index.
    always_comb begin
        widx     = addr[7:2];
        side     = addr[12];
        dsc_idx  = widx[IW-1:0];
        word_sel = widx[0];
        kind     = K_NONE;
        if (addr[1:0] == 2'b00) begin
            case (addr[11:8])
                PG_MISC: begin
                    case (widx)
                        6'd0:    kind = side ? K_FILL : K_BASE;
                        6'd1:    kind = K_CTRL;
                        6'd2:    kind = K_FSTAT;
                        6'd3:    kind = K_FADDR;
                        default: kind = K_NONE;
                    endcase
                end
                PG_DADDR: if ({1'b0, widx} < NDESC_L) kind = K_DADDR;
                PG_DATTR: if ({1'b0, widx} < NDESC_L) kind = K_DATTR;
                PG_TCMD:  if (widx == 6'd0) kind = K_TCMD;
                PG_TDATA: if (widx < 6'd2) kind = K_TDATA;
                default:  kind = K_NONE;
            endcase
        end
        hit = (kind != K_NONE);
    end

endmodule

// File: rtl/pr_xfer_seq.sv
// Two-beat sequencer moving 64 bits between the test data words and SRAM.
// Assumes read data arrives one cycle after a read beat and line_addr is
// held stable while busy.
module pr_xfer_seq
    import prot_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir_wr_in,
    input  logic [WORD_W-1:0] line_addr,
    input  logic [WORD_W-1:0] word_lo,
    input  logic [WORD_W-1:0] word_hi,
    output logic              busy,
    output logic              sram_en,
    output logic              sram_we,
    output logic [WORD_W-1:0] sram_addr,
    output logic [WORD_W-1:0] sram_wdata,
    output logic              cap_lo,
    output logic              cap_hi
);
    xfer_state_e st_q;
    logic        dir_q;

    // Advance through the beats; reads take one extra cycle to collect data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= XS_IDLE;
            dir_q <= 1'b0;
        end else begin
            case (st_q)
                XS_IDLE: if (start) begin
                    st_q  <= XS_BEAT0;
                    dir_q <= dir_wr_in;
                end
                XS_BEAT0: st_q <= XS_BEAT1;
                XS_BEAT1: st_q <= dir_q ? XS_IDLE : XS_TAIL;
                default:  st_q <= XS_IDLE;
            endcase
        end
    end

    // Drive the SRAM beat and capture strobes from the state.
    always_comb begin
        busy       = (st_q != XS_IDLE);
        sram_en    = (st_q == XS_BEAT0) || (st_q == XS_BEAT1);
        sram_we    = sram_en && dir_q;
        sram_addr  = line_addr | {29'd0, (st_q == XS_BEAT1), 2'b00};
        sram_wdata = (st_q == XS_BEAT1) ? word_hi : word_lo;
        cap_lo     = (st_q == XS_BEAT1) && !dir_q;
        cap_hi     = (st_q == XS_TAIL);
    end

endmodule

// File: rtl/prot_regbank.sv
// Register bank of a memory-protection unit, with data and instruction groups,
// a fault-logger input and an indirect SRAM test path.
// Assumes the bus master waits for busy to fall before further writes.
module prot_regbank
    import prot_regbank_pkg::*;
#(
    parameter int                NDESC    = 16,
    parameter logic [WORD_W-1:0] BASE_RST = 32'hFF80_0000,
    parameter logic [WORD_W-1:0] CTRL_RST = 32'h0000_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic              bus_full,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic              busy,
    input  logic              flt_valid,
    input  logic              flt_inst,
    input  logic [WORD_W-1:0] flt_status,
    input  logic [WORD_W-1:0] flt_addr,
    output logic              sram_en,
    output logic              sram_we,
    output logic [WORD_W-1:0] sram_addr,
    output logic [WORD_W-1:0] sram_wdata,
    input  logic [WORD_W-1:0] sram_rdata
);
    localparam int IW = (NDESC > 1) ? $clog2(NDESC) : 1;

    logic              hit, side, word_sel;
    reg_kind_e         kind;
    logic [IW-1:0]     dsc_idx;

    logic [WORD_W-1:0] ctrl_q   [2];
    logic [WORD_W-1:0] fstat_q  [2];
    logic [WORD_W-1:0] faddr_q  [2];
    logic [WORD_W-1:0] daddr_q  [2][NDESC];
    logic [WORD_W-1:0] dattr_q  [2][NDESC];
    logic [WORD_W-1:0] tdata_q  [2][2];
    logic [WORD_W-1:0] dcmd_q;

    logic acc, wr_go, rd_go, reject, start, err_d;
    logic cap_lo, cap_hi;
    logic [WORD_W-1:0] rd_mux, line_addr;

    pr_addr_decode #(.NDESC(NDESC)) u_dec (
        .addr     (bus_addr),
        .hit      (hit),
        .side     (side),
        .kind     (kind),
        .dsc_idx  (dsc_idx),
        .word_sel (word_sel)
    );

    // Qualify the request: writes are held off while a transfer runs.
    always_comb begin
        acc    = bus_req && !(busy && bus_we);
        wr_go  = acc && bus_we && bus_full && hit;
        rd_go  = acc && !bus_we && bus_full && hit;
        reject = bus_we && (kind == K_TCMD) && (bus_wdata != '0)
                 && (side || !cmd_legal(bus_wdata));
        start  = wr_go && (kind == K_TCMD) && !side && (bus_wdata != '0)
                 && cmd_legal(bus_wdata);
        err_d  = acc && (!bus_full || !hit || reject);
        line_addr = form_line_addr(dcmd_q, BASE_RST);
    end

    pr_xfer_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .dir_wr_in  (bus_wdata[CMD_WRITE_BIT]),
        .line_addr  (line_addr),
        .word_lo    (tdata_q[0][0]),
        .word_hi    (tdata_q[0][1]),
        .busy       (busy),
        .sram_en    (sram_en),
        .sram_we    (sram_we),
        .sram_addr  (sram_addr),
        .sram_wdata (sram_wdata),
        .cap_lo     (cap_lo),
        .cap_hi     (cap_hi)
    );

    // Select the word a read returns.
    always_comb begin
        case (kind)
            K_BASE:  rd_mux = BASE_RST;
            K_CTRL:  rd_mux = ctrl_q[side];
            K_FSTAT: rd_mux = fstat_q[side];
            K_FADDR: rd_mux = faddr_q[side];
            K_DADDR: rd_mux = daddr_q[side][dsc_idx];
            K_DATTR: rd_mux = dattr_q[side][dsc_idx];
            K_TCMD:  rd_mux = side ? '0 : dcmd_q;
            K_TDATA: rd_mux = tdata_q[side][word_sel];
            default: rd_mux = '0;
        endcase
    end

    // Register the bus response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_rdata <= rd_go ? rd_mux : '0;
            bus_err   <= err_d;
        end
    end

    // Update stored registers from the bus, the fault logger and the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dcmd_q <= '0;
            for (int s = 0; s < 2; s++) begin
                ctrl_q[s]     <= CTRL_RST;
                fstat_q[s]    <= '0;
                faddr_q[s]    <= '0;
                tdata_q[s][0] <= '0;
                tdata_q[s][1] <= '0;
                for (int i = 0; i < NDESC; i++) begin
                    daddr_q[s][i] <= '0;
                    dattr_q[s][i] <= '0;
                end
            end
        end else begin
            if (wr_go) begin
                case (kind)
                    K_CTRL:  ctrl_q[side]              <= bus_wdata;
                    K_DADDR: daddr_q[side][dsc_idx]    <= bus_wdata;
                    K_DATTR: dattr_q[side][dsc_idx]    <= bus_wdata;
                    K_TDATA: tdata_q[side][word_sel]   <= bus_wdata;
                    K_TCMD:  if (!side) dcmd_q         <= bus_wdata;
                    default: ;
                endcase
            end
            if (flt_valid) begin
                fstat_q[flt_inst] <= flt_status;
                faddr_q[flt_inst] <= flt_addr;
            end
            if (cap_lo) tdata_q[0][0] <= sram_rdata;
            if (cap_hi) tdata_q[0][1] <= sram_rdata;
        end
    end

endmodule

// File: rtl/prot_regbank_chk.sv
// Property checker for prot_regbank, attached by bind below.
// Assumes SRAM read latency of one cycle and flt_valid low during reset.
module prot_regbank_chk #(
    parameter logic [31:0] BASE = 32'hFF80_0000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        bus_err,
    input logic [31:0] bus_rdata,
    input logic        sram_en,
    input logic        sram_we,
    input logic [31:0] sram_addr,
    input logic        flt_valid,
    input logic [31:0] fstat_d,
    input logic [31:0] fstat_i
);
    a_r8_beat_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        sram_en |-> busy);

    a_r10_no_start_with_err: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !bus_err);

    a_r8_second_beat_next_word: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_en) |=> sram_en && (sram_addr == ($past(sram_addr) | 32'h4)));

    a_r9_direction_steady: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_en) |=> (sram_we == $past(sram_we)));

    a_r7_base_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
        sram_en |-> ((sram_addr & BASE) == BASE));

    a_r2_err_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == 32'h0));

    a_r6_status_only_by_logger: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(flt_valid) |-> ($stable(fstat_d) && $stable(fstat_i)));

endmodule

bind prot_regbank prot_regbank_chk #(.BASE(BASE_RST)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .bus_err   (bus_err),
    .bus_rdata (bus_rdata),
    .sram_en   (sram_en),
    .sram_we   (sram_we),
    .sram_addr (sram_addr),
    .flt_valid (flt_valid),
    .fstat_d   (fstat_q[0]),
    .fstat_i   (fstat_q[1])
);

// File: tb/tb_prot_regbank.sv
// Self-checking bench with a behavioural register model and SRAM model.
module tb_prot_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0, bus_full = 1'b1;
    logic [12:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err, busy;
    logic        flt_valid = 1'b0, flt_inst = 1'b0;
    logic [31:0] flt_status = '0, flt_addr = '0;
    logic        sram_en, sram_we;
    logic [31:0] sram_addr, sram_wdata;
    logic [31:0] sram_rdata = '0;

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] mdl [int];
    logic [31:0] mem [logic [31:0]];
    logic [31:0] op_addr [$];
    logic        op_we   [$];
    logic [31:0] op_data [$];

    always #2 clk = ~clk;

    prot_regbank dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_full(bus_full), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .busy(busy),
        .flt_valid(flt_valid), .flt_inst(flt_inst), .flt_status(flt_status),
        .flt_addr(flt_addr), .sram_en(sram_en), .sram_we(sram_we),
        .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata)
    );

    // SRAM model with one-cycle read latency, logging every beat.
    always @(posedge clk) begin
        if (sram_en) begin
            op_addr.push_back(sram_addr);
            op_we.push_back(sram_we);
            op_data.push_back(sram_wdata);
            if (sram_we) mem[sram_addr] = sram_wdata;
            else sram_rdata <= mem.exists(sram_addr) ? mem[sram_addr] : 32'h0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit m_mapped(input int a);
        int o;
        if ((a & 3) != 0 || a >= 'h2000) return 0;
        o = a & 'hFFF;
        return (o < 'h10) || (o >= 'h100 && o < 'h140) || (o >= 'h200 && o < 'h240)
               || o == 'h300 || o == 'h400 || o == 'h404;
    endfunction

    function automatic bit m_stores(input int a);
        int o;
        o = a & 'hFFF;
        return (o == 4) || (o >= 'h100 && o < 'h140) || (o >= 'h200 && o < 'h240)
               || o == 'h400 || o == 'h404 || a == 'h300;
    endfunction

    function automatic bit m_legal(input logic [31:0] d);
        return d[2] && ((d & 32'hFA7C_B801) == 0);
    endfunction

    function automatic logic [31:0] m_line(input logic [31:0] d);
        return 32'hFF80_0000 | {10'b0, d[24], 5'b0, d[23], d[14], d[17:16],
                                d[26], d[10:3], 3'b0};
    endfunction

    function automatic logic [31:0] m_val(input int a);
        return mdl.exists(a) ? mdl[a] : 32'h0;
    endfunction

    task automatic rd(input int a, input bit full, input string req);
        bit e;
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_full = full; bus_addr = 13'(a);
        @(negedge clk);
        bus_req = 0; bus_full = 1;
        e = !full || !m_mapped(a);
        chk({req, " read err"}, {31'b0, bus_err}, {31'b0, e});
        chk({req, " read data"}, bus_rdata, e ? 32'h0 : m_val(a));
    endtask

    task automatic wr(input int a, input logic [31:0] d, input bit full, input string req);
        bit e;
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_full = full; bus_addr = 13'(a); bus_wdata = d;
        @(negedge clk);
        bus_req = 0; bus_we = 0; bus_full = 1;
        e = !full || !m_mapped(a) || (a == 'h300 && d != 0 && !m_legal(d))
            || (a == 'h1300 && d != 0);
        if (full && m_mapped(a) && m_stores(a)) mdl[a] = d;
        chk({req, " write err"}, {31'b0, bus_err}, {31'b0, e});
    endtask

    // Issue a test command, follow busy every clock, then compare SRAM beats.
    task automatic tcmd(input logic [31:0] d, input bit intrude, input string req);
        logic [31:0] a;
        int cyc;
        op_addr.delete(); op_we.delete(); op_data.delete();
        wr('h300, d, 1, req);
        if (d == 0 || !m_legal(d)) begin
            chk({req, " no busy"}, {31'b0, busy}, 32'h0);
            @(negedge clk);
            chk({req, " no beats"}, op_addr.size(), 0);
            return;
        end
        a = m_line(d);
        cyc = d[1] ? 2 : 3;
        for (int k = 0; k < cyc; k++) begin
            chk({req, " busy"}, {31'b0, busy}, 32'h1);
            if (intrude && k == 0) begin
                bus_req = 1; bus_we = 1; bus_addr = 13'h104; bus_wdata = 32'hDEAD_0001;
            end
            @(negedge clk);
            if (intrude && k == 0) begin
                bus_req = 0; bus_we = 0;
                chk("R11 write during busy err", {31'b0, bus_err}, 32'h0);
            end
        end
        chk({req, " busy done"}, {31'b0, busy}, 32'h0);
        chk({req, " beat count"}, op_addr.size(), 2);
        if (op_addr.size() == 2) begin
            chk("R7 beat0 addr", op_addr[0], a);
            chk("R7 beat1 addr", op_addr[1], a + 4);
            chk({req, " dir0"}, {31'b0, op_we[0]}, {31'b0, d[1]});
            chk({req, " dir1"}, {31'b0, op_we[1]}, {31'b0, d[1]});
            if (d[1]) begin
                chk("R8 word0 out", op_data[0], m_val('h400));
                chk("R8 word1 out", op_data[1], m_val('h404));
            end
        end
        if (!d[1]) begin
            mdl['h400] = mem.exists(a) ? mem[a] : 32'h0;
            mdl['h404] = mem.exists(a + 4) ? mem[a + 4] : 32'h0;
        end
    endtask

    task automatic flog(input bit inst, input logic [31:0] st, input logic [31:0] ad);
        @(negedge clk);
        flt_valid = 1; flt_inst = inst; flt_status = st; flt_addr = ad;
        @(negedge clk);
        flt_valid = 0;
        mdl[inst ? 'h1008 : 'h008] = st;
        mdl[inst ? 'h100C : 'h00C] = ad;
    endtask

    initial begin
        #(4 * 150000);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        mdl['h000] = 32'hFF80_0000;
        mdl['h004] = 32'h1;
        mdl['h1004] = 32'h1;
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R3 reset values
        rd('h000, 1, "R3"); rd('h004, 1, "R3"); rd('h1004, 1, "R3");
        rd('h008, 1, "R3"); rd('h1000, 1, "R3"); rd('h300, 1, "R3");
        rd('h13C, 1, "R3"); chk("R3 busy", {31'b0, busy}, 32'h0);

        // R4 read/write storage
        wr('h100, 32'h1234_5678, 1, "R4"); wr('h13C, 32'hA5A5_0F0F, 1, "R4");
        wr('h200, 32'h0003_0001, 1, "R4"); wr('h1100, 32'hCAFE_F00D, 1, "R4");
        wr('h123C, 32'h8000_0001, 1, "R4"); wr('h004, 32'h0, 1, "R4");
        wr('h1404, 32'h7777_1111, 1, "R4");
        rd('h100, 1, "R4"); rd('h13C, 1, "R4"); rd('h200, 1, "R4");
        rd('h1100, 1, "R4"); rd('h123C, 1, "R4"); rd('h004, 1, "R4");
        rd('h1404, 1, "R4"); rd('h1004, 1, "R4");

        // R5 dropped writes
        wr('h000, 32'h1, 1, "R5"); wr('h008, 32'hFFFF, 1, "R5");
        wr('h00C, 32'h44, 1, "R5"); wr('h1000, 32'h9, 1, "R5");
        wr('h1008, 32'h5, 1, "R5"); wr('h100C, 32'h6, 1, "R5");
        rd('h000, 1, "R5"); rd('h008, 1, "R5"); rd('h00C, 1, "R5");
        rd('h1000, 1, "R5"); rd('h1008, 1, "R5"); rd('h100C, 1, "R5");

        // R1 size errors
        wr('h104, 32'hBAD0_0001, 0, "R1"); rd('h104, 1, "R1");
        rd('h100, 0, "R1"); rd('h777, 0, "R1");

        // R2 unmapped offsets
        rd('h010, 1, "R2"); rd('h140, 1, "R2"); rd('h302, 1, "R2");
        rd('h304, 1, "R2"); rd('h408, 1, "R2"); rd('h500, 1, "R2");
        rd('h1240, 1, "R2"); wr('h1140, 32'h1, 1, "R2");

        // R6 fault logger
        flog(0, 32'h000A_0003, 32'h0040_1000);
        rd('h008, 1, "R6"); rd('h00C, 1, "R6"); rd('h1008, 1, "R6");
        flog(1, 32'h0002_0000, 32'hFFA0_0010);
        rd('h1008, 1, "R6"); rd('h100C, 1, "R6"); rd('h008, 1, "R6");

        // R8 write direction, R7 address forming
        wr('h400, 32'h0101_0202, 1, "R8"); wr('h404, 32'h0303_0404, 1, "R8");
        tcmd(32'h0581_45AE, 0, "R8");
        chk("R8 sram lo", mem[m_line(32'h0581_45AE)], 32'h0101_0202);
        chk("R8 sram hi", mem[m_line(32'h0581_45AE) + 4], 32'h0303_0404);

        // R9 read direction
        mem[m_line(32'h0002_07FC)]     = 32'h5555_AAAA;
        mem[m_line(32'h0002_07FC) + 4] = 32'h0BAD_BEEF;
        tcmd(32'h0002_07FC, 0, "R9");
        rd('h400, 1, "R9"); rd('h404, 1, "R9"); rd('h1404, 1, "R9");

        // R10 refused commands
        tcmd(32'h0000_0805, 0, "R10");
        tcmd(32'h0000_0002, 0, "R10");
        op_addr.delete();
        wr('h1300, 32'h0000_0004, 1, "R10");
        @(negedge clk);
        chk("R10 itest no beats", op_addr.size(), 0);
        rd('h400, 1, "R10");

        // R12 command readback
        rd('h300, 1, "R12"); rd('h1300, 1, "R12");

        // R11 zero command and writes while busy
        tcmd(32'h0, 0, "R11");
        rd('h300, 1, "R11");
        mem[m_line(32'h0000_0014)]     = 32'h1357_9BDF;
        mem[m_line(32'h0000_0014) + 4] = 32'h2468_ACE0;
        tcmd(32'h0000_0014, 1, "R11");
        rd('h104, 1, "R11"); rd('h400, 1, "R11"); rd('h404, 1, "R11");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule